// File: doc/BRIEF.md
# Nested-Loop Sensor Clock Pattern Sequencer

This block generates the multi-phase clock bus that shifts charge through an image sensor during clearing, exposure and readout. It holds a small fixed library of recipes. Each recipe is an ordered list of steps, and each step drives one 30-bit phase word for a programmed number of clock ticks. The phase words are composites: each named phase owns one bit, and a step word is the OR of the phases that are high during that step.

A run plays an outer recipe a chosen number of times. On every outer pass, the outer recipe's steps play first. The inner recipe then plays its full repeat count. A single start pulse latches the two recipe selections and the two repeat counts. The output word is registered, so every phase bit changes on the same clock edge. When the run finishes, the bus returns to the hold word and a one-cycle done pulse is given.

Top module: `clkseq_pattern_gen`

## Requirements
- R1: After reset, phase_q equals the hold word, and busy and done are both 0. Whenever busy is 0, phase_q equals the hold word.
- R2: Phase bit positions are fixed. Vertical phases: 1A at bit 0, 3B at bit 1, 2 at bit 2, 3A at bit 3, 1B at bit 4. Horizontal phases: 3A at bit 5, 3B at bit 6, 2 at bit 7, 1A at bit 8, 1B at bit 9. Summing well: A at bit 10, B at bit 11. Reset gate: bits 12 and 13. Output gate: bits 14 and 15. Dump gate: bits 16 and 17. Transfer gate: bits 18 and 19. Spare strobes sit at bits 21 to 24. Marker 1 is bit 25 and marker 2 is bit 26. Bits 20 and 27 to 29 are always 0. The hold word is vertical 1A, 1B, 3A and 3B, horizontal 1A, 1B, 3A and 3B, and both bits of the reset, output, dump and transfer gates.
- R3: A step drives its word unchanged for exactly its tick count, then the next step's word appears on the following cycle.
- R4: Recipe id 1 (vertical transfer) has six steps of 300 ticks. Every step carries horizontal 1 and 3, reset, output and dump gates. The vertical phases by step are: {1,3}, {1}, {1,2}, {2}, {2,3}, {3}. Transfer gate is high only in the last step.
- R5: Recipe id 2 (horizontal shift) has eight steps: hold plus summing well for 12 ticks, then six 150-tick steps, then a 15-tick step with the reset gate low. The six middle steps are: summing well high with dump gate low and horizontal {1A,3B}; then {1A,2,3B}; {2}; {1B,2,3A}; {1B,3A}; and the plain hold word. Each of these middle steps carries vertical 1 and 3. Apart from the first, each carries the reset, output, dump and transfer gates. Recipe id 3 (drain) is the first two steps of recipe id 2.
- R6: Recipe id 0 is the hold word for 150 ticks. Recipe id 4 (raw read) is the hold word plus marker 2 for 20 ticks, then the hold word for 20 ticks.
- R7: Each outer pass plays the outer recipe once, then the inner recipe inner_reps times. With the default counts, a hold outer pass and 1000 raw inner passes give 40,150 busy cycles.
- R8: With inner_reps = 0, only the outer recipe repeats. With outer_reps = 0, a start plays no step and done pulses on the next cycle.
- R9: A step whose tick count is 0 lasts exactly one cycle.
- R10: After the last tick of the last step, busy falls, phase_q returns to the hold word and done is 1 for exactly one cycle.
- R11: A start pulse while busy is 1 is ignored: the sequence and its selections and counts are unchanged.
- R12: Recipe id 5 (exposure) holds the hold word for 15,000,000 ticks, so the dwell counter is at least 24 bits wide.
- R13: Recipe ids 6 and 7 play as recipe id 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request, taken only when idle |
| outer_sel | input | 3 | Outer recipe id |
| inner_sel | input | 3 | Inner recipe id |
| outer_reps | input | 16 | Outer pass count |
| inner_reps | input | 16 | Inner repetitions per outer pass |
| phase_q | output | 30 | Registered clock-phase word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench compares the bus on every cycle against a behavioural model for several runs. The default hold/raw readout shows the basic two-step pattern. A vertical-outer/horizontal-inner run shows that outer steps come before inner ones and that each step has its own dwell. A drain run with no inner passes and a run with zero outer passes show the empty-loop edges. A second instance with zero-tick raw steps shows the one-cycle minimum. A mid-run start with other selections must leave the stream untouched. Unknown recipe ids must fall back to hold, and a long exposure must stay busy past a 16-bit count.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int PH_W = 30;
  typedef logic [PH_W-1:0] phase_t;

  localparam int BIT_VPH1_A = 0;
  localparam int BIT_VPH3_B = 1;
  localparam int BIT_VPH2   = 2;
  localparam int BIT_VPH3_A = 3;
  localparam int BIT_VPH1_B = 4;
  localparam int BIT_HPH3_A = 5;
  localparam int BIT_HPH3_B = 6;
  localparam int BIT_HPH2   = 7;
  localparam int BIT_HPH1_A = 8;
  localparam int BIT_HPH1_B = 9;
  localparam int BIT_SUMW   = 10;
  localparam int BIT_RSTG   = 12;
  localparam int BIT_OUTG   = 14;
  localparam int BIT_DUMP   = 16;
  localparam int BIT_XFER   = 18;
  localparam int BIT_MARK2  = 26;

  localparam phase_t ONE    = phase_t'(1);
  localparam phase_t PAIR   = phase_t'(3);

  localparam phase_t W_V1   = (ONE << BIT_VPH1_A) | (ONE << BIT_VPH1_B);
  localparam phase_t W_V3   = (ONE << BIT_VPH3_A) | (ONE << BIT_VPH3_B);
  localparam phase_t W_V2   = ONE << BIT_VPH2;
  localparam phase_t W_H1A  = ONE << BIT_HPH1_A;
  localparam phase_t W_H1B  = ONE << BIT_HPH1_B;
  localparam phase_t W_H3A  = ONE << BIT_HPH3_A;
  localparam phase_t W_H3B  = ONE << BIT_HPH3_B;
  localparam phase_t W_H2   = ONE << BIT_HPH2;
  localparam phase_t W_H13  = W_H1A | W_H1B | W_H3A | W_H3B;
  localparam phase_t W_SW   = PAIR << BIT_SUMW;
  localparam phase_t W_RG   = PAIR << BIT_RSTG;
  localparam phase_t W_OG   = PAIR << BIT_OUTG;
  localparam phase_t W_DG   = PAIR << BIT_DUMP;
  localparam phase_t W_TG   = PAIR << BIT_XFER;
  localparam phase_t W_MK2  = ONE << BIT_MARK2;

  // parked word: vertical 1/3, horizontal 1/3, all gates high
  localparam phase_t HOLD_WORD = W_V1 | W_V3 | W_H13 | W_RG | W_OG | W_DG | W_TG;
  // common part of the vertical transfer steps
  localparam phase_t VBASE     = W_H13 | W_RG | W_OG | W_DG;
  // common part of the horizontal shift steps
  localparam phase_t HBASE     = W_V1 | W_V3 | W_RG | W_OG | W_DG | W_TG;

  typedef enum logic [2:0] {
    REC_HOLD   = 3'd0,
    REC_VERT   = 3'd1,
    REC_HSHIFT = 3'd2,
    REC_DRAIN  = 3'd3,
    REC_RAW    = 3'd4,
    REC_EXPOSE = 3'd5
  } rec_id_t;

  localparam int STEP_W = 4;
  typedef logic [STEP_W-1:0] step_t;

  function automatic rec_id_t rec_norm(input logic [2:0] id);
    case (id)
      3'd1:    return REC_VERT;
      3'd2:    return REC_HSHIFT;
      3'd3:    return REC_DRAIN;
      3'd4:    return REC_RAW;
      3'd5:    return REC_EXPOSE;
      default: return REC_HOLD;
    endcase
  endfunction

  function automatic step_t rec_len(input rec_id_t r);
    case (r)
      REC_VERT:   return step_t'(6);
      REC_HSHIFT: return step_t'(8);
      REC_DRAIN:  return step_t'(2);
      REC_RAW:    return step_t'(2);
      default:    return step_t'(1);
    endcase
  endfunction

  function automatic phase_t hshift_word(input step_t s);
    case (s)
      step_t'(0): return HOLD_WORD | W_SW;
      step_t'(1): return (HBASE & ~W_DG) | W_SW | W_H1A | W_H3B;
      step_t'(2): return HBASE | W_H1A | W_H2 | W_H3B;
      step_t'(3): return HBASE | W_H2;
      step_t'(4): return HBASE | W_H1B | W_H2 | W_H3A;
      step_t'(5): return HBASE | W_H1B | W_H3A;
      step_t'(6): return HOLD_WORD;
      default:    return HOLD_WORD & ~W_RG;
    endcase
  endfunction

  function automatic phase_t vert_word(input step_t s);
    case (s)
      step_t'(0): return VBASE | W_V1 | W_V3;
      step_t'(1): return VBASE | W_V1;
      step_t'(2): return VBASE | W_V1 | W_V2;
      step_t'(3): return VBASE | W_V2;
      step_t'(4): return VBASE | W_V2 | W_V3;
      default:    return VBASE | W_V3 | W_TG;
    endcase
  endfunction

  function automatic phase_t step_word(input rec_id_t r, input step_t s);
    case (r)
      REC_VERT:   return vert_word(s);
      REC_HSHIFT: return hshift_word(s);
      REC_DRAIN:  return hshift_word(s);
      REC_RAW:    return (s == step_t'(0)) ? (HOLD_WORD | W_MK2) : HOLD_WORD;
      default:    return HOLD_WORD;
    endcase
  endfunction
endpackage

// File: rtl/clkseq_step_rom.sv
module clkseq_step_rom
  import clkseq_pkg::*;
#(
  parameter int DLY_W    = 24,
  parameter int T_VOVL   = 300,
  parameter int T_HOVL   = 150,
  parameter int T_SUMW   = 12,
  parameter int T_RGW    = 15,
  parameter int T_RAWRD  = 20,
  parameter int T_NORD   = 20,
  parameter int T_HOLD   = 150,
  parameter int T_EXPOSE = 15000000
) (
  input  rec_id_t          rec,
  input  step_t            step,
  output phase_t           word,
  output logic [DLY_W-1:0] dly
);
  localparam logic [DLY_W-1:0] D_VOVL = DLY_W'(T_VOVL);
  localparam logic [DLY_W-1:0] D_HOVL = DLY_W'(T_HOVL);
  localparam logic [DLY_W-1:0] D_SUMW = DLY_W'(T_SUMW);
  localparam logic [DLY_W-1:0] D_RGW  = DLY_W'(T_RGW);
  localparam logic [DLY_W-1:0] D_RAW  = DLY_W'(T_RAWRD);
  localparam logic [DLY_W-1:0] D_NORD = DLY_W'(T_NORD);
  localparam logic [DLY_W-1:0] D_HOLD = DLY_W'(T_HOLD);
  localparam logic [DLY_W-1:0] D_EXP  = DLY_W'(T_EXPOSE);

  always_comb begin
    word = step_word(rec, step);
    case (rec)
      REC_VERT:   dly = D_VOVL;
      REC_HSHIFT: begin
        if (step == step_t'(0))      dly = D_SUMW;
        else if (step == step_t'(7)) dly = D_RGW;
        else                         dly = D_HOVL;
      end
      REC_DRAIN:  dly = (step == step_t'(0)) ? D_SUMW : D_HOVL;
      REC_RAW:    dly = (step == step_t'(0)) ? D_RAW : D_NORD;
      REC_EXPOSE: dly = D_EXP;
      default:    dly = D_HOLD;
    endcase
  end
endmodule

// File: rtl/clkseq_dwell_timer.sv
module clkseq_dwell_timer #(
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             last
);
  localparam logic [DLY_W-1:0] ONE_T = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = (load_val == '0) ? ONE_T : load_val;
    else      cnt_d = cnt_q - ONE_T;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == ONE_T);

  // a freshly entered step always owns at least one tick
  p_reload_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0));
endmodule

// File: rtl/clkseq_loop_ctrl.sv
module clkseq_loop_ctrl
  import clkseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       outer_sel,
  input  logic [2:0]       inner_sel,
  input  logic [CNT_W-1:0] outer_reps,
  input  logic [CNT_W-1:0] inner_reps,
  input  logic             step_last,
  output logic             busy,
  output logic             enter,
  output logic             fin,
  output rec_id_t          nxt_rec,
  output step_t            nxt_step
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic             busy_q, busy_d;
  logic             inner_q, inner_d;
  step_t            step_q, step_d;
  logic [CNT_W-1:0] oleft_q, oleft_d;
  logic [CNT_W-1:0] ileft_q, ileft_d;
  logic [CNT_W-1:0] itot_q, itot_d;
  rec_id_t          ro_q, ro_d, ri_q, ri_d;
  rec_id_t          cur_rec;
  logic             at_last, upd_en;

  assign cur_rec = inner_q ? ri_q : ro_q;
  assign at_last = (step_q == rec_len(cur_rec) - step_t'(1));
  assign upd_en  = (!busy_q && start) || (busy_q && step_last);

  always_comb begin
    busy_d  = busy_q;
    inner_d = inner_q;
    step_d  = step_q;
    oleft_d = oleft_q;
    ileft_d = ileft_q;
    itot_d  = itot_q;
    ro_d    = ro_q;
    ri_d    = ri_q;
    enter   = 1'b0;
    fin     = 1'b0;
    if (!busy_q) begin
      if (start) begin
        ro_d    = rec_norm(outer_sel);
        ri_d    = rec_norm(inner_sel);
        itot_d  = inner_reps;
        oleft_d = outer_reps;
        inner_d = 1'b0;
        step_d  = '0;
        if (outer_reps == '0) begin
          fin = 1'b1;
        end else begin
          busy_d = 1'b1;
          enter  = 1'b1;
        end
      end
    end else if (step_last) begin
      enter = 1'b1;
      if (!at_last) begin
        step_d = step_q + step_t'(1);
      end else begin
        step_d = '0;
        if (!inner_q && (itot_q != '0)) begin
          inner_d = 1'b1;
          ileft_d = itot_q;
        end else if (inner_q && (ileft_q > ONE_C)) begin
          ileft_d = ileft_q - ONE_C;
        end else if (oleft_q > ONE_C) begin
          inner_d = 1'b0;
          oleft_d = oleft_q - ONE_C;
        end else begin
          enter   = 1'b0;
          fin     = 1'b1;
          busy_d  = 1'b0;
          inner_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      inner_q <= 1'b0;
      step_q  <= '0;
      oleft_q <= '0;
      ileft_q <= '0;
      itot_q  <= '0;
      ro_q    <= REC_HOLD;
      ri_q    <= REC_HOLD;
    end else if (upd_en) begin
      busy_q  <= busy_d;
      inner_q <= inner_d;
      step_q  <= step_d;
      oleft_q <= oleft_d;
      ileft_q <= ileft_d;
      itot_q  <= itot_d;
      ro_q    <= ro_d;
      ri_q    <= ri_d;
    end
  end

  assign busy     = busy_q;
  assign nxt_rec  = inner_d ? ri_d : ro_d;
  assign nxt_step = step_d;

  p_step_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_q < rec_len(cur_rec)));
  p_inner_needs_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && inner_q) |-> (itot_q != '0));
endmodule

// File: rtl/clkseq_pattern_gen.sv
module clkseq_pattern_gen
  import clkseq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DLY_W    = 24,
  parameter int T_VOVL   = 300,
  parameter int T_HOVL   = 150,
  parameter int T_SUMW   = 12,
  parameter int T_RGW    = 15,
  parameter int T_RAWRD  = 20,
  parameter int T_NORD   = 20,
  parameter int T_HOLD   = 150,
  parameter int T_EXPOSE = 15000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       outer_sel,
  input  logic [2:0]       inner_sel,
  input  logic [CNT_W-1:0] outer_reps,
  input  logic [CNT_W-1:0] inner_reps,
  output logic [PH_W-1:0]  phase_q,
  output logic             busy,
  output logic             done
);
  logic             enter, fin, step_last;
  rec_id_t          nxt_rec;
  step_t            nxt_step;
  phase_t           rom_word, phase_d, phase_r;
  logic [DLY_W-1:0] rom_dly;
  logic             phase_en, done_r;

  clkseq_loop_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .outer_sel(outer_sel), .inner_sel(inner_sel),
    .outer_reps(outer_reps), .inner_reps(inner_reps),
    .step_last(step_last), .busy(busy), .enter(enter), .fin(fin),
    .nxt_rec(nxt_rec), .nxt_step(nxt_step)
  );

  clkseq_step_rom #(
    .DLY_W(DLY_W), .T_VOVL(T_VOVL), .T_HOVL(T_HOVL), .T_SUMW(T_SUMW),
    .T_RGW(T_RGW), .T_RAWRD(T_RAWRD), .T_NORD(T_NORD), .T_HOLD(T_HOLD),
    .T_EXPOSE(T_EXPOSE)
  ) u_rom (
    .rec(nxt_rec), .step(nxt_step), .word(rom_word), .dly(rom_dly)
  );

  clkseq_dwell_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(enter), .load_val(rom_dly),
    .last(step_last)
  );

  always_comb begin
    phase_en = enter || fin;
    phase_d  = enter ? rom_word : HOLD_WORD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_r <= HOLD_WORD;
    else if (phase_en) phase_r <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_r <= 1'b0;
    else        done_r <= fin;
  end

  assign phase_q = phase_r;
  assign done    = done_r;

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (phase_q == HOLD_WORD));
  p_hold_in_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_last) |=> $stable(phase_q));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && phase_q == HOLD_WORD));
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step_last) |=> (busy && $stable(phase_q)));
endmodule

// File: tb/clkseq_pattern_gen_tb_top.sv
module clkseq_pattern_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  start_w = 2'b00;
  logic [2:0]  osel = 3'd0, isel = 3'd0;
  logic [15:0] onum = 16'd0, inum = 16'd0;
  logic [29:0] phase_w [2];
  logic        busy_w [2];
  logic        done_w [2];

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  clkseq_pattern_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start_w[0]),
    .outer_sel(osel), .inner_sel(isel), .outer_reps(onum), .inner_reps(inum),
    .phase_q(phase_w[0]), .busy(busy_w[0]), .done(done_w[0])
  );

  clkseq_pattern_gen #(.T_RAWRD(0), .T_NORD(0)) dut_z (
    .clk(clk), .rst_n(rst_n), .start(start_w[1]),
    .outer_sel(osel), .inner_sel(isel), .outer_reps(onum), .inner_reps(inum),
    .phase_q(phase_w[1]), .busy(busy_w[1]), .done(done_w[1])
  );

  // phase words rebuilt from the bit positions of R2
  function automatic logic [29:0] bt(input int n);
    return 30'(1) << n;
  endfunction
  function automatic logic [29:0] pr(input int n);
    return 30'(3) << n;
  endfunction

  logic [29:0] v1, v3, v2, h1a, h1b, h3a, h3b, h2, sw, rg, og, dg, tg, mk2, hold_w;
  initial begin
    v1 = bt(0) | bt(4);  v3 = bt(1) | bt(3);  v2 = bt(2);
    h3a = bt(5); h3b = bt(6); h2 = bt(7); h1a = bt(8); h1b = bt(9);
    sw = pr(10); rg = pr(12); og = pr(14); dg = pr(16); tg = pr(18);
    mk2 = bt(26);
    hold_w = v1 | v3 | h1a | h1b | h3a | h3b | rg | og | dg | tg;
  end

  function automatic int nrm(input int id);
    return (id > 5) ? 0 : id;
  endfunction

  function automatic int m_len(input int id);
    case (nrm(id))
      1: return 6;
      2: return 8;
      3: return 2;
      4: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int m_dly(input int u, input int id, input int k);
    int d;
    case (nrm(id))
      1: d = 300;
      2: d = (k == 0) ? 12 : ((k == 7) ? 15 : 150);
      3: d = (k == 0) ? 12 : 150;
      4: d = (u == 1) ? 0 : 20;
      5: d = 15000000;
      default: d = 150;
    endcase
    return (d < 1) ? 1 : d;
  endfunction

  function automatic logic [29:0] m_word(input int id, input int k);
    logic [29:0] vb, hb;
    vb = h1a | h1b | h3a | h3b | rg | og | dg;
    hb = v1 | v3 | rg | og | dg | tg;
    case (nrm(id))
      1: case (k)
           0: return vb | v1 | v3;
           1: return vb | v1;
           2: return vb | v1 | v2;
           3: return vb | v2;
           4: return vb | v2 | v3;
           default: return vb | v3 | tg;
         endcase
      2, 3: case (k)
           0: return hold_w | sw;
           1: return v1 | v3 | rg | og | tg | sw | h1a | h3b;
           2: return hb | h1a | h2 | h3b;
           3: return hb | h2;
           4: return hb | h1b | h2 | h3a;
           5: return hb | h1b | h3a;
           6: return hold_w;
           default: return hold_w & ~rg;
         endcase
      4: return (k == 0) ? (hold_w | mk2) : hold_w;
      default: return hold_w;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_rec(input int u, input int id, ref logic [29:0] q[$]);
    for (int k = 0; k < m_len(id); k++)
      for (int t = 0; t < m_dly(u, id, k); t++) q.push_back(m_word(id, k));
  endtask

  // plays one run and compares the bus cycle by cycle against the model
  task automatic run_case(input int u, input int oid, input int iid,
                          input int no, input int ni, input int poke,
                          input string req);
    logic [29:0] q[$];
    int bad = -1;
    logic [29:0] bad_act = '0, bad_exp = '0;
    for (int p = 0; p < no; p++) begin
      push_rec(u, oid, q);
      for (int r = 0; r < ni; r++) push_rec(u, iid, q);
    end
    @(negedge clk);
    osel = oid[2:0]; isel = iid[2:0]; onum = no[15:0]; inum = ni[15:0];
    start_w[u] = 1'b1;
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      start_w[u] = 1'b0;
      if (i == poke) begin
        osel = 3'd1; isel = 3'd2; onum = 16'd9; inum = 16'd9;
        start_w[u] = 1'b1;   // R11: must be ignored while busy
      end
      if (bad < 0 && (phase_w[u] !== q[i] || busy_w[u] !== 1'b1)) begin
        bad = i; bad_act = phase_w[u]; bad_exp = q[i];
      end
    end
    @(negedge clk);
    start_w[u] = 1'b0;
    check(bad < 0, req, $sformatf("stream mismatch at cycle %0d", bad),
          bad_act, bad_exp);
    check(done_w[u] === 1'b1 && busy_w[u] === 1'b0 && phase_w[u] === hold_w,
          "R10", "end of run done/busy/hold", {done_w[u], busy_w[u], phase_w[u]},
          {1'b1, 1'b0, hold_w});
    @(negedge clk);
    check(done_w[u] === 1'b0, "R10", "done one cycle only", done_w[u], 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check(phase_w[0] === hold_w && busy_w[0] === 1'b0 && done_w[0] === 1'b0,
          "R1", "reset state", phase_w[0], hold_w);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase_w[0] === hold_w, "R2", "hold word bit layout", phase_w[0], hold_w);

    // R6 R7: default readout, hold outer once, raw inner 1000 times
    run_case(0, 0, 4, 1, 1000, -1, "R7_R6");
    // R4 R5 R3: vertical outer with horizontal inner
    run_case(0, 1, 2, 2, 3, -1, "R4_R5_R3");
    // R8 R5: drain with no inner passes
    run_case(0, 3, 4, 3, 0, -1, "R8_R5");
    // R8: zero outer passes
    run_case(0, 2, 2, 0, 5, -1, "R8");
    // R11: start pulse in the middle of a run
    run_case(0, 4, 0, 2, 2, 57, "R11");
    // R9: zero-tick steps on the second instance
    run_case(1, 4, 4, 2, 1, -1, "R9");
    // R13: unknown recipe ids fall back to hold
    run_case(0, 7, 6, 1, 1, -1, "R13");

    // R12: exposure outlasts a 16-bit count
    @(negedge clk);
    osel = 3'd5; isel = 3'd0; onum = 16'd1; inum = 16'd0;
    start_w[0] = 1'b1;
    @(negedge clk);
    start_w[0] = 1'b0;
    check(busy_w[0] === 1'b1 && phase_w[0] === hold_w, "R12", "exposure entry",
          phase_w[0], hold_w);
    repeat (70000) @(negedge clk);
    check(busy_w[0] === 1'b1 && done_w[0] === 1'b0, "R12",
          "exposure still running after 70000 ticks", busy_w[0], 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule